// File: doc/BRIEF.md
# SPI Master Controller with Register Port

The block is an SPI bus master that software drives through a small 32-bit register port. Words to send are written into one data register, which feeds a transmit queue. Words received from the bus are read back from the same register, which drains a receive queue. A shift engine takes words from the transmit queue, moves them out on the serial data line one bit per serial clock period, and samples the input line at the same time. Each word sent produces exactly one received word, so a read-only transfer is made by sending dummy words.

Word length (2 to 32 bits), clock polarity and phase, bit order for each direction, a divider for the serial clock, and internal loopback are set in the control registers. Two chip-select pins each have their own active level, and one of them is chosen per frame. A frame normally closes as soon as the transmit queue runs dry. A hold bit keeps the frame open, with chip select asserted, until software clears it. A status flag then reports that the frame has closed.

The register port is a plain synchronous port with no back-pressure. An access completes in the cycle it is presented, and read data appears one cycle later. Writes to a full transmit queue are dropped. The serial engine never stalls on a full receive queue: the received word is discarded and an overrun flag records the loss.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0x10 (only the receive-empty bit 4 set), both chip-select pins are high and the serial clock is low.
- R2: A write to offset 0x00 queues a transmit word and a read of offset 0x00 returns and removes the oldest received word. With loopback on, the received word equals the sent word masked to the word length, where the length field in bits [7:3] of offset 0x08 holds length minus two. This holds for every length from 2 to 32.
- R3: Bit 19 of offset 0x04 makes transmission LSB-first and bit 17 makes reception LSB-first. When the two orders differ, the received word is the bit-reversal of the sent word within the word length.
- R4: Each serial clock level lasts div+1 clock cycles, where div is bits [7:0] of offset 0x18.
- R5: Bit 0 of offset 0x08 sets the idle serial clock level (CPOL). Bit 1 sets the phase (CPHA). Data round-trips correctly in all four modes.
- R6: Bit 6 of offset 0x04 chooses pin 1 instead of pin 0. Bit 30 and bit 31 of offset 0x08 make pin 0 and pin 1 active-high. The pin that is not chosen stays at its inactive level.
- R7: While bit 23 of offset 0x08 (hold) is set, an empty transmit queue leaves the frame open, with chip select asserted and busy (status bit 6) set. Further queued words continue in the same frame, and clearing hold closes it.
- R8: Status bit 7 (frame done) is set when a frame closes and cleared when the next frame opens.
- R9: Status bit 1 (underrun) is set when a frame closes because the transmit queue emptied while hold was clear, and is not set by a close caused by clearing hold. Writing 0 to status bit 1 or bit 0 clears that flag.
- R10: A received word that arrives while the receive queue holds 128 words is dropped and status bit 0 (overrun) is set. The 128 stored words are kept.
- R11: Bit 2 of offset 0x04 empties the transmit queue and bit 1 empties the receive queue. Both read back as 0.
- R12: With bit 7 of offset 0x04 set, the receive queue is emptied when a frame opens.
- R13: No frame opens while bit 15 of offset 0x04 (enable) is clear. Status bit 5 reports a full transmit queue (128 words) and bit 2 reports at least 64 received words.
- R14: With loopback (bit 10 of offset 0x04) clear, received bits come from the serial input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_pin | output | 2 | Chip-select pins, level set per pin |

## Verification
Register reads return data one cycle after the access. The bench therefore drives accesses on the falling edge and takes read data at the next falling edge.

A word of length N takes 2·N·(div+1) cycles on the wire, plus two cycles to reach the engine. Rather than predict an exact cycle, the bench polls busy (or receive-empty, when a hold frame is open) and then reads results. Pin levels are checked only while a hold frame is parked, which holds them steady.

Serial clock timing is measured directly: the bench counts falling edges across one high level of the clock and compares the count with div+1.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W  = $clog2(DATA_W);
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CTLA = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTLB = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 5'h18;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_LEAD,
    ENG_TRAIL,
    ENG_HOLD
  } eng_state_t;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             tx_lsb;
    logic             rx_lsb;
    logic [LEN_W-1:0] flen;
  } word_cfg_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         do_push, do_pop;

  assign count   = wp - rp;
  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (wp == rp);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp[AW-1:0]] <= wdata;
  end

  // R10: a push into a full queue without a pop leaves the fill level unchanged
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> $stable(count));

  // R11: a clear leaves the queue empty on the next cycle
  p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [7:0]        div,
  input  word_cfg_t         cfg,
  input  logic              hold,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso_in,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              frame_open,
  output logic              frame_start,
  output logic              frame_close,
  output logic              starve,
  output logic              sclk,
  output logic              mosi
);
  eng_state_t        st;
  word_cfg_t         cfg_q;
  logic [DATA_W-1:0] txw, rxw, rx_next;
  logic [LEN_W-1:0]  bidx, top_bit, tx_pos, rx_pos;
  logic [7:0]        tcnt;
  logic              half_done, last_bit, word_end, lead_lvl;

  assign top_bit   = cfg_q.flen + LEN_W'(1);
  assign tx_pos    = cfg_q.tx_lsb ? bidx : (top_bit - bidx);
  assign rx_pos    = cfg_q.rx_lsb ? bidx : (top_bit - bidx);
  assign half_done = (tcnt == div);
  assign last_bit  = (bidx == top_bit);
  assign word_end  = (st == ENG_TRAIL) && half_done && last_bit;
  assign rx_next   = rxw | (DATA_W'(miso_in) << rx_pos);
  assign lead_lvl  = cfg_q.cpol ^ cfg_q.cpha;

  assign frame_open  = (st != ENG_IDLE);
  assign frame_start = (st == ENG_IDLE) && enable && !tx_empty;
  assign tx_pop      = frame_start || (word_end && !tx_empty) ||
                       ((st == ENG_HOLD) && !tx_empty);
  assign starve      = word_end && tx_empty && !hold;
  assign frame_close = starve || ((st == ENG_HOLD) && tx_empty && !hold);
  assign rx_push     = (st == ENG_LEAD) && half_done && last_bit;
  assign rx_word     = rx_next;

  always_comb begin
    case (st)
      ENG_LEAD:  sclk = lead_lvl;
      ENG_TRAIL: sclk = ~lead_lvl;
      default:   sclk = cfg.cpol;
    endcase
    mosi = ((st == ENG_LEAD) || (st == ENG_TRAIL)) ? txw[tx_pos] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ENG_IDLE;
      cfg_q <= '0;
      txw   <= '0;
      rxw   <= '0;
      bidx  <= '0;
      tcnt  <= '0;
    end else begin
      case (st)
        ENG_IDLE: if (frame_start) begin
          cfg_q <= cfg;
          txw   <= tx_word;
          rxw   <= '0;
          bidx  <= '0;
          tcnt  <= '0;
          st    <= ENG_LEAD;
        end
        ENG_LEAD: if (half_done) begin
          rxw  <= rx_next;
          tcnt <= '0;
          st   <= ENG_TRAIL;
        end else begin
          tcnt <= tcnt + 8'd1;
        end
        ENG_TRAIL: if (half_done) begin
          tcnt <= '0;
          if (!last_bit) begin
            bidx <= bidx + LEN_W'(1);
            st   <= ENG_LEAD;
          end else if (!tx_empty) begin
            txw  <= tx_word;
            rxw  <= '0;
            bidx <= '0;
            st   <= ENG_LEAD;
          end else if (hold) begin
            st <= ENG_HOLD;
          end else begin
            st <= ENG_IDLE;
          end
        end else begin
          tcnt <= tcnt + 8'd1;
        end
        default: if (!tx_empty) begin
          txw  <= tx_word;
          rxw  <= '0;
          bidx <= '0;
          tcnt <= '0;
          st   <= ENG_LEAD;
        end else if (!hold) begin
          st <= ENG_IDLE;
        end
      endcase
    end
  end

  // R4: the serial clock holds its level until the half period is used up
  p_sclk_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ENG_LEAD) && !half_done) |=> $stable(sclk));

  // R7: a parked frame only resumes when a word is available
  p_hold_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ENG_HOLD) && tx_empty && hold) |=> (st == ENG_HOLD));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 128,
  parameter int unsigned NUM_SS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_pin
);
  localparam int unsigned CW   = $clog2(FIFO_DEPTH) + 1;
  localparam int unsigned HALF = FIFO_DEPTH / 2;

  // control A
  logic tx_lsb, rx_lsb, en, loop, autoclr, ss_sel;
  // control B
  logic [NUM_SS-1:0] ss_pol;
  logic              hold, cpha, cpol;
  logic [LEN_W-1:0]  flen;
  logic [7:0]        div_q;
  logic              end_q, undr_q, over_q, owner;

  logic wr, rd, wr_ctla, wr_stat;
  logic tx_push, tx_pop, tx_full, tx_empty, tx_flush;
  logic rx_push, rx_pop, rx_full, rx_empty, rx_clr;
  logic [DATA_W-1:0] tx_word, rx_word, rx_head;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic frame_open, frame_start, frame_close, starve, busy, miso_in;
  word_cfg_t cfg;
  logic [NUM_SS-1:0] ss_act;

  assign wr       = bus_sel && bus_wr;
  assign rd       = bus_sel && !bus_wr;
  assign wr_ctla  = wr && (bus_addr == OFS_CTLA);
  assign wr_stat  = wr && (bus_addr == OFS_STAT);
  assign tx_push  = wr && (bus_addr == OFS_DATA);
  assign rx_pop   = rd && (bus_addr == OFS_DATA);
  assign tx_flush = wr_ctla && bus_wdata[2];
  assign rx_clr   = (wr_ctla && bus_wdata[1]) || (frame_start && autoclr);
  assign busy     = frame_open || (en && !tx_empty);
  assign miso_in  = loop ? mosi : miso;
  assign cfg      = '{cpol: cpol, cpha: cpha, tx_lsb: tx_lsb, rx_lsb: rx_lsb, flen: flen};

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_flush), .push(tx_push), .wdata(bus_wdata),
    .pop(tx_pop), .rdata(tx_word), .full(tx_full), .empty(tx_empty), .count(tx_cnt));

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_cnt));

  spim_engine u_eng (
    .clk(clk), .rst_n(rst_n), .enable(en), .div(div_q), .cfg(cfg), .hold(hold),
    .tx_empty(tx_empty), .tx_word(tx_word), .miso_in(miso_in), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_word(rx_word), .frame_open(frame_open),
    .frame_start(frame_start), .frame_close(frame_close), .starve(starve),
    .sclk(sclk), .mosi(mosi));

  for (genvar j = 0; j < NUM_SS; j++) begin : g_ss
    assign ss_act[j] = frame_open && (owner == j[0]);
    assign ss_pin[j] = ss_pol[j] ? ss_act[j] : !ss_act[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {tx_lsb, rx_lsb, en, loop, autoclr, ss_sel} <= '0;
      ss_pol <= '0;
      hold   <= 1'b0;
      cpha   <= 1'b0;
      cpol   <= 1'b0;
      flen   <= '0;
      div_q  <= '0;
      owner  <= 1'b0;
    end else begin
      if (wr_ctla) begin
        tx_lsb  <= bus_wdata[19];
        rx_lsb  <= bus_wdata[17];
        en      <= bus_wdata[15];
        loop    <= bus_wdata[10];
        autoclr <= bus_wdata[7];
        ss_sel  <= bus_wdata[6];
      end
      if (wr && (bus_addr == OFS_CTLB)) begin
        ss_pol <= bus_wdata[31:30];
        hold   <= bus_wdata[23];
        flen   <= bus_wdata[7:3];
        cpha   <= bus_wdata[1];
        cpol   <= bus_wdata[0];
      end
      if (wr && (bus_addr == OFS_DIV)) div_q <= bus_wdata[7:0];
      if (frame_start) owner <= ss_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q  <= 1'b0;
      undr_q <= 1'b0;
      over_q <= 1'b0;
    end else begin
      if (frame_close)      end_q <= 1'b1;
      else if (frame_start) end_q <= 1'b0;
      if (starve)           undr_q <= 1'b1;
      else if (wr_stat)     undr_q <= undr_q && bus_wdata[1];
      if (rx_push && rx_full) over_q <= 1'b1;
      else if (wr_stat)       over_q <= over_q && bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd) begin
      case (bus_addr)
        OFS_DATA: bus_rdata <= rx_empty ? '0 : rx_head;
        OFS_CTLA: bus_rdata <= {12'b0, tx_lsb, 1'b0, rx_lsb, 1'b0, en, 4'b0, loop,
                                2'b0, autoclr, ss_sel, 6'b0};
        OFS_CTLB: bus_rdata <= {ss_pol, 6'b0, hold, 15'b0, flen, 1'b0, cpha, cpol};
        OFS_STAT: bus_rdata <= {24'b0, end_q, busy, tx_full, rx_empty, 1'b0,
                                (rx_cnt >= CW'(HALF)), undr_q, over_q};
        OFS_DIV:  bus_rdata <= {24'b0, div_q};
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R10: overrun only rises after a word met a full receive queue
  p_over_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_q) |-> $past(rx_push && rx_full));

  // R8: the done flag is never seen while a frame is open
  p_end_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> !frame_open);

  // R6: at most one chip select is active
  p_one_ss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ss_act));

  // R9: writing 0 to the underrun bit clears it unless a new underrun occurs
  p_undr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bus_wdata[1] && !starve) |=> !undr_q);

  // R13: nothing opens while disabled
  p_no_start_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !frame_open) |=> !frame_open);
endmodule

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [1:0]  ss_pin;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  spim_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_pin(ss_pin));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ca(input bit en, input bit lp, input bit ac, input bit sel,
                                     input bit txl, input bit rxl);
    return (32'(en) << 15) | (32'(lp) << 10) | (32'(ac) << 7) | (32'(sel) << 6) |
           (32'(txl) << 19) | (32'(rxl) << 17);
  endfunction

  function automatic logic [31:0] cb(input bit p1, input bit p0, input bit hd, input int len,
                                     input bit cph, input bit cpl);
    return (32'(p1) << 31) | (32'(p0) << 30) | (32'(hd) << 23) | (32'(len - 2) << 3) |
           (32'(cph) << 1) | 32'(cpl);
  endfunction

  function automatic logic [31:0] lenmask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  function automatic logic [31:0] revw(input logic [31:0] v, input int len);
    logic [31:0] r = '0;
    for (int i = 0; i < len; i++) r[len-1-i] = v[i];
    return r;
  endfunction

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      rd(5'h0C, s);
      if (!s[6]) break;
    end
  endtask

  task automatic wait_rx();
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      rd(5'h0C, s);
      if (!s[4]) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d, s, v, exp;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h0C, s);
    check("R1 status", s, 32'h10);
    check("R1 pins", {30'b0, ss_pin}, 32'h3);
    check("R1 sclk", {31'b0, sclk}, 32'h0);

    // R2 R3 R5 sweep: all lengths, modes and bit orders in loopback
    wr(5'h18, 32'h0);
    for (int len = 2; len <= 32; len++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int ord = 0; ord < 4; ord++) begin
          v = 32'hA5C3_96E1 ^ (32'(len) * 32'h0101_0101) ^ (32'(mode * 4 + ord) << 9);
          wr(5'h08, cb(0, 0, 0, len, mode[1], mode[0]));
          wr(5'h04, ca(1, 1, 0, 0, ord[1], ord[0]));
          wr(5'h00, v);
          wait_idle();
          rd(5'h00, d);
          exp = (ord[1] == ord[0]) ? (v & lenmask(len)) : revw(v & lenmask(len), len);
          check($sformatf("R2 R3 R5 len=%0d mode=%0d ord=%0d", len, mode, ord), d, exp);
        end
      end
    end

    // R5 idle clock level follows CPOL
    wr(5'h08, cb(0, 0, 0, 8, 0, 1));
    @(negedge clk);
    check("R5 idle high", {31'b0, sclk}, 32'h1);
    wr(5'h08, cb(0, 0, 0, 8, 0, 0));
    @(negedge clk);
    check("R5 idle low", {31'b0, sclk}, 32'h0);

    // R4 divider: one high level lasts div+1 cycles
    for (int dv = 0; dv < 6; dv++) begin
      wr(5'h18, 32'(dv * 2));
      wr(5'h08, cb(0, 0, 0, 4, 0, 0));
      wr(5'h04, ca(1, 1, 0, 0, 0, 0));
      wr(5'h00, 32'h5);
      for (int k = 0; k < 200 && !sclk; k++) @(negedge clk);
      n = 0;
      while (sclk && n < 1000) begin
        @(negedge clk);
        n++;
      end
      check($sformatf("R4 div=%0d", dv * 2), 32'(n), 32'(dv * 2 + 1));
      wait_idle();
      rd(5'h00, d);
    end
    wr(5'h18, 32'h0);

    // R8 R9 normal close sets done and underrun, and writing 0 clears the flags
    rd(5'h0C, s);
    check("R8 done after frame", {31'b0, s[7]}, 32'h1);
    check("R9 underrun after frame", {31'b0, s[1]}, 32'h1);
    wr(5'h0C, 32'h0);
    rd(5'h0C, s);
    check("R9 underrun cleared", {31'b0, s[1]}, 32'h0);

    // R6 R7 hold frame on pin 1, active high
    wr(5'h08, cb(1, 0, 1, 16, 0, 0));
    wr(5'h04, ca(1, 1, 0, 1, 0, 0));
    wr(5'h00, 32'h1234);
    wait_rx();
    rd(5'h0C, s);
    check("R7 busy while parked", {31'b0, s[6]}, 32'h1);
    check("R8 done cleared at open", {31'b0, s[7]}, 32'h0);
    check("R6 pin1 active high, pin0 idle", {30'b0, ss_pin}, 32'h3);
    rd(5'h00, d);
    check("R7 first word", d, 32'h1234);
    wr(5'h00, 32'hBEEF);
    wait_rx();
    check("R7 frame still open", {30'b0, ss_pin}, 32'h3);
    rd(5'h00, d);
    check("R7 second word", d, 32'hBEEF);
    wr(5'h08, cb(1, 0, 0, 16, 0, 0));
    wait_idle();
    rd(5'h0C, s);
    check("R8 done after release", {31'b0, s[7]}, 32'h1);
    check("R9 no underrun on release", {31'b0, s[1]}, 32'h0);
    check("R6 pins idle after release", {30'b0, ss_pin}, 32'h1);

    // R6 pin 0 active high while pin 1 stays inactive
    wr(5'h08, cb(0, 1, 1, 8, 0, 0));
    wr(5'h04, ca(1, 1, 0, 0, 0, 0));
    wr(5'h00, 32'h3C);
    wait_rx();
    check("R6 pin0 active high", {30'b0, ss_pin}, 32'h3);
    wr(5'h08, cb(0, 1, 0, 8, 0, 0));
    wait_idle();
    check("R6 pin0 released", {30'b0, ss_pin}, 32'h2);
    rd(5'h00, d);
    check("R6 data", d, 32'h3C);

    // R14 external serial input
    wr(5'h08, cb(0, 0, 0, 12, 1, 1));
    wr(5'h04, ca(1, 0, 0, 0, 0, 0));
    miso = 1'b1;
    wr(5'h00, 32'h0);
    wait_idle();
    rd(5'h00, d);
    check("R14 input ones", d, 32'hFFF);
    miso = 1'b0;
    wr(5'h00, 32'hFFF);
    wait_idle();
    rd(5'h00, d);
    check("R14 input zeros", d, 32'h0);

    // R12 receive queue cleared when a frame opens
    wr(5'h08, cb(0, 0, 0, 8, 0, 0));
    wr(5'h04, ca(1, 1, 1, 0, 0, 0));
    wr(5'h00, 32'h11);
    wait_idle();
    wr(5'h00, 32'h22);
    wait_idle();
    rd(5'h00, d);
    check("R12 only newest word", d, 32'h22);
    rd(5'h0C, s);
    check("R12 queue empty", {31'b0, s[4]}, 32'h1);

    // R13 R10 half-full, full and overrun
    wr(5'h08, cb(0, 0, 0, 2, 0, 0));
    wr(5'h04, ca(1, 1, 0, 0, 0, 0));
    wr(5'h0C, 32'h0);
    for (int i = 0; i < 63; i++) wr(5'h00, 32'(i));
    wait_idle();
    rd(5'h0C, s);
    check("R13 63 words not half", {31'b0, s[2]}, 32'h0);
    wr(5'h00, 32'(63));
    wait_idle();
    rd(5'h0C, s);
    check("R13 64 words half", {31'b0, s[2]}, 32'h1);
    for (int i = 64; i < 128; i++) wr(5'h00, 32'(i));
    wait_idle();
    rd(5'h0C, s);
    check("R10 no overrun at 128", {31'b0, s[0]}, 32'h0);
    wr(5'h00, 32'h3);
    wait_idle();
    rd(5'h0C, s);
    check("R10 overrun set", {31'b0, s[0]}, 32'h1);
    n = 0;
    for (int i = 0; i < 128; i++) begin
      rd(5'h00, d);
      if (d !== 32'(i & 3)) n++;
    end
    check("R10 stored words kept", 32'(n), 32'h0);
    rd(5'h0C, s);
    check("R10 queue drained", {31'b0, s[4]}, 32'h1);
    wr(5'h0C, 32'h0);
    rd(5'h0C, s);
    check("R9 overrun cleared", {31'b0, s[0]}, 32'h0);

    // R13 R11 disabled controller fills, flush empties
    wr(5'h04, ca(0, 1, 0, 0, 0, 0));
    for (int i = 0; i < 128; i++) wr(5'h00, 32'(i));
    rd(5'h0C, s);
    check("R13 transmit full", {31'b0, s[5]}, 32'h1);
    check("R13 disabled not busy", {31'b0, s[6]}, 32'h0);
    check("R13 nothing received", {31'b0, s[4]}, 32'h1);
    wr(5'h04, ca(0, 1, 0, 0, 0, 0) | 32'h4);
    rd(5'h04, d);
    check("R11 flush bits read 0", d, ca(0, 1, 0, 0, 0, 0));
    rd(5'h0C, s);
    check("R11 transmit emptied", {31'b0, s[5]}, 32'h0);
    wr(5'h04, ca(1, 1, 0, 0, 0, 0));
    repeat (40) @(negedge clk);
    rd(5'h0C, s);
    check("R11 no words left to send", {31'b0, s[4]}, 32'h1);
    for (int i = 0; i < 3; i++) wr(5'h00, 32'(i + 1));
    wait_idle();
    wr(5'h04, ca(1, 1, 0, 0, 0, 0) | 32'h2);
    rd(5'h0C, s);
    check("R11 receive emptied", {31'b0, s[4]}, 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule